// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wakeup

This block is a relative alarm measured in seconds. Software loads an interval into a 32-bit register. Once counting is enabled, a one-cycle pulse from a one-second time base lowers the live count by one. When the count steps from one to zero, a sticky pending flag is raised. The count then rests at zero.

The pending flag feeds two outputs. The interrupt line asserts when the flag is set and the interrupt enable bit is set. The wakeup line asserts when the flag is set and the wakeup enable bit is set. Software clears the flag by writing a one to its status bit.

A second set of registers exists only as a placeholder for a calendar-style alarm. It has an enable, an interrupt enable and a clearable pending bit. These registers reset to zero and affect nothing else.

Registers are reached through a single-cycle register port. A write lands on the rising edge where the write strobe is high. Reads are combinational from the address.

Top module: `secs_alarm`

## Requirements
- R1: After reset, every register reads 0 and both `irq` and `wake_out` are low.
- R2: A write to offset 0x20 sets the interval register and the live count (read at 0x24) to the written value. Writing 0 clears the count. A load takes priority over a tick in the same cycle.
- R3: While bit 0 of offset 0x28 is 1, each `sec_tick` pulse lowers the live count by exactly one. While that bit is 0, ticks leave the count unchanged.
- R4: A tick that takes the count from 1 to 0 sets the pending flag (bit 0 of offset 0x30). After that the count stays at 0, and further ticks neither change it nor set the flag again.
- R5: `irq` equals the pending flag ANDed with bit 0 of offset 0x2C.
- R6: `wake_out` equals the pending flag ANDed with bit 0 of offset 0x50.
- R7: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R8: If a clear write and a 1-to-0 countdown step land in the same cycle, the pending flag ends up set.
- R9: Bit 0 of offsets 0x44 and 0x48 (placeholder alarm enable and interrupt enable) can be written and read back. Bit 0 of offset 0x4C (placeholder pending) reads 0, and writing 1 to it keeps it at 0. None of these touch `irq`.
- R10: Loading 0, or ticking while the count is already 0, never sets the pending flag.
- R11: The full-range interval 0xFFFFFFFF loads and counts down to 0xFFFFFFFE on one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt: pending AND interrupt enable |
| wake_out | output | 1 | Wakeup: pending AND wakeup enable |

## Verification
The countdown is exercised with several interval values:
- A short interval is ticked with counting disabled and then enabled. This separates gating from decrementing.
- Zero is loaded. This shows that a clear does not raise the flag.
- An interval of three is run past zero. This shows the flag fires once and the count parks.
- The full 32-bit value is loaded. This exposes width or wrap faults.

The status bit is written with 0, with 1, and with 1 in the same cycle as the final tick. This distinguishes a correct write-one-to-clear from a plain write and confirms that set wins. The enable bits are toggled while the flag is pending to show the gating of each output.

// File: rtl/secalm_pkg.sv
// Package: register offsets shared by the countdown alarm and its checker.
// Assumes byte offsets fit in 8 bits.
package secalm_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_INTERVAL = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_LIVE     = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_RUN      = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_WK_EN    = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_WK_IEN   = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_WK_STAT  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_WAKE_EN  = 8'h50;

    // Index of each sticky flag in the flag array
    localparam int FLAG_CNT  = 0;
    localparam int FLAG_WEEK = 1;
    localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/alm_countdown.sv
// Module: loadable seconds down-counter.
// A load has priority over a tick. A tick lowers a non-zero count by one while
// run is high. fire pulses in the cycle whose tick moves the count from 1 to 0.
// Assumes tick is a one-cycle pulse synchronous to clk.
module alm_countdown #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         fire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;

    // Decide whether this cycle consumes a tick
    always_comb begin
        step = run && tick && !load && (count != '0);
        fire = step && (count == ONE);
    end

    // Hold, load or decrement the live count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/alm_w1c_flag.sv
// Module: sticky flag with write-one-to-clear.
// When set and clr arrive in the same cycle, set wins.
module alm_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Update the sticky flag, giving priority to the set event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/alm_regfile.sv
// Module: register decode for the countdown alarm.
// Holds the interval and the control bits, raises load and clear strobes,
// and drives the combinational read mux.
// Assumes one register access per cycle; reads have no side effects.
module alm_regfile
    import secalm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] live_count,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic              load_stb,
    output logic [DATA_W-1:0] load_val,
    output logic [NUM_FLAGS-1:0] clr_stb,
    output logic              run_en,
    output logic              irq_en,
    output logic              wake_en
);
    logic [DATA_W-1:0] interval_q;
    logic              wk_en_q;
    logic              wk_ien_q;

    // Write strobes derived from the address decode
    always_comb begin
        load_stb           = bus_wr && (bus_addr == OFF_INTERVAL);
        load_val           = bus_wdata;
        clr_stb            = '0;
        clr_stb[FLAG_CNT]  = bus_wr && (bus_addr == OFF_STATUS)  && bus_wdata[0];
        clr_stb[FLAG_WEEK] = bus_wr && (bus_addr == OFF_WK_STAT) && bus_wdata[0];
    end

    // Store the interval and the single-bit control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= '0;
            run_en     <= 1'b0;
            irq_en     <= 1'b0;
            wake_en    <= 1'b0;
            wk_en_q    <= 1'b0;
            wk_ien_q   <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_INTERVAL: interval_q <= bus_wdata;
                OFF_RUN:      run_en     <= bus_wdata[0];
                OFF_IRQ_EN:   irq_en     <= bus_wdata[0];
                OFF_WAKE_EN:  wake_en    <= bus_wdata[0];
                OFF_WK_EN:    wk_en_q    <= bus_wdata[0];
                OFF_WK_IEN:   wk_ien_q   <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Select the read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_INTERVAL: bus_rdata    = interval_q;
            OFF_LIVE:     bus_rdata    = live_count;
            OFF_RUN:      bus_rdata[0] = run_en;
            OFF_IRQ_EN:   bus_rdata[0] = irq_en;
            OFF_STATUS:   bus_rdata[0] = flags[FLAG_CNT];
            OFF_WAKE_EN:  bus_rdata[0] = wake_en;
            OFF_WK_EN:    bus_rdata[0] = wk_en_q;
            OFF_WK_IEN:   bus_rdata[0] = wk_ien_q;
            OFF_WK_STAT:  bus_rdata[0] = flags[FLAG_WEEK];
            default:      bus_rdata    = '0;
        endcase
    end
endmodule

// File: rtl/secs_alarm.sv
// Module: top of the seconds countdown alarm.
// Ties the register decode, the down-counter and the sticky pending flags
// together, and gates the pending flag onto the interrupt and wakeup outputs.
// Assumes sec_tick is a single-cycle pulse in the clk domain.
module secs_alarm
    import secalm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake_out
);
    logic [DATA_W-1:0]    cnt_val;
    logic [DATA_W-1:0]    load_val;
    logic                 load_stb;
    logic                 run_en;
    logic                 irq_en;
    logic                 wake_en;
    logic                 cnt_fire;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    alm_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .live_count (cnt_val),
        .flags      (flag_q),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .clr_stb    (flag_clr),
        .run_en     (run_en),
        .irq_en     (irq_en),
        .wake_en    (wake_en)
    );

    alm_countdown #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_stb),
        .load_val (load_val),
        .run      (run_en),
        .tick     (sec_tick),
        .count    (cnt_val),
        .fire     (cnt_fire)
    );

    // Set sources: the countdown drives its flag; the placeholder has none
    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_CNT]  = cnt_fire;
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        alm_w1c_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[gi]),
            .clr   (flag_clr[gi]),
            .flag  (flag_q[gi])
        );
    end

    // Gate the pending flag onto both outputs
    always_comb begin
        irq      = flag_q[FLAG_CNT] && irq_en;
        wake_out = flag_q[FLAG_CNT] && wake_en;
    end
endmodule

// File: rtl/secs_alarm_checker.sv
// Module: temporal properties for secs_alarm, attached with bind.
module secs_alarm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              load,
    input logic [DATA_W-1:0] load_val,
    input logic [DATA_W-1:0] count,
    input logic              fire,
    input logic              pend,
    input logic              clr_pend,
    input logic              irq_en,
    input logic              wake_en,
    input logic              irq,
    input logic              wake
);
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count != '0) |=> count == $past(count) - 1'b1);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !load) |=> $stable(count));
    p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && count == DATA_W'(1)) |=> pend);
    p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> count == '0);
    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    p_wake_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_en |-> !wake);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !fire) |=> !pend);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && clr_pend) |=> pend);
    p_no_false_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !fire) |=> !pend);
endmodule

bind secs_alarm secs_alarm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .run      (run_en),
    .load     (load_stb),
    .load_val (load_val),
    .count    (cnt_val),
    .fire     (cnt_fire),
    .pend     (flag_q[0]),
    .clr_pend (flag_clr[0]),
    .irq_en   (irq_en),
    .wake_en  (wake_en),
    .irq      (irq),
    .wake     (wake_out)
);

// File: tb/secs_alarm_test.sv
`timescale 1ns/1ps
module secs_alarm_test;
    typedef struct {
        int          kind;   // 0: bus_rdata, 1: irq, 2: wake_out
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        wake_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;

    secs_alarm uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wake_out  (wake_out)
    );

    // Monitor: pop expected items and compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                case (it.kind)
                    0:       got = bus_rdata;
                    1:       got = {31'b0, irq};
                    default: got = {31'b0, wake_out};
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d addr=%02h got=%08h exp=%08h",
                             it.tag, it.kind, bus_addr, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic pin(input int k, input logic e, input string tag);
        item_t it;
        @(negedge clk);
        it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver: stimulus and expected results
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h20, 0, "R1"); rd(8'h24, 0, "R1"); rd(8'h28, 0, "R1");
        rd(8'h2C, 0, "R1"); rd(8'h30, 0, "R1"); rd(8'h50, 0, "R1");
        rd(8'h44, 0, "R1"); rd(8'h48, 0, "R1"); rd(8'h4C, 0, "R1");
        pin(1, 1'b0, "R1"); pin(2, 1'b0, "R1");

        // R2: load an interval
        wr(8'h20, 32'd5, 1'b0);
        rd(8'h20, 32'd5, "R2"); rd(8'h24, 32'd5, "R2");

        // R3: ticks without run have no effect
        tick(); tick();
        rd(8'h24, 32'd5, "R3 gated");

        // R3: counting enabled
        wr(8'h28, 32'd1, 1'b0);
        rd(8'h28, 32'd1, "R3");
        tick();
        rd(8'h24, 32'd4, "R3");
        tick(); tick();
        rd(8'h24, 32'd2, "R3");

        // R2 priority: load and tick together, load wins
        wr(8'h20, 32'd9, 1'b1);
        rd(8'h24, 32'd9, "R2 load wins");

        // R10: loading zero clears without pending
        wr(8'h20, 32'd0, 1'b0);
        rd(8'h24, 32'd0, "R2 clear");
        tick();
        rd(8'h30, 32'd0, "R10");

        // R4: countdown to zero raises pending once
        wr(8'h20, 32'd3, 1'b0);
        tick(); tick();
        rd(8'h30, 32'd0, "R4 early");
        tick();
        rd(8'h24, 32'd0, "R4");
        rd(8'h30, 32'd1, "R4");
        pin(1, 1'b0, "R5 masked");
        pin(2, 1'b0, "R6 masked");
        tick();
        rd(8'h24, 32'd0, "R4 parked");

        // R5 / R6: output gating
        wr(8'h2C, 32'd1, 1'b0);
        pin(1, 1'b1, "R5");
        pin(2, 1'b0, "R6");
        wr(8'h50, 32'd1, 1'b0);
        pin(2, 1'b1, "R6");

        // R7: write-one-to-clear
        wr(8'h30, 32'd0, 1'b0);
        rd(8'h30, 32'd1, "R7 write0");
        wr(8'h30, 32'd1, 1'b0);
        rd(8'h30, 32'd0, "R7");
        pin(1, 1'b0, "R7 irq");
        pin(2, 1'b0, "R7 wake");

        // R10: ticks at zero do not re-raise
        tick(); tick();
        rd(8'h30, 32'd0, "R10 no refire");

        // R8: clear in the same cycle as the final tick
        wr(8'h20, 32'd1, 1'b0);
        wr(8'h30, 32'd1, 1'b1);
        rd(8'h30, 32'd1, "R8");
        pin(1, 1'b1, "R8 irq");
        wr(8'h30, 32'd1, 1'b0);
        rd(8'h30, 32'd0, "R8 cleared");

        // R11: full-range interval
        wr(8'h20, 32'hFFFF_FFFF, 1'b0);
        rd(8'h24, 32'hFFFF_FFFF, "R11");
        tick();
        rd(8'h24, 32'hFFFF_FFFE, "R11");

        // R3: disable stops counting
        wr(8'h28, 32'd0, 1'b0);
        tick();
        rd(8'h24, 32'hFFFF_FFFE, "R3 disabled");

        // R9: placeholder registers
        wr(8'h44, 32'd1, 1'b0);
        rd(8'h44, 32'd1, "R9");
        wr(8'h48, 32'd1, 1'b0);
        rd(8'h48, 32'd1, "R9");
        wr(8'h4C, 32'd1, 1'b0);
        rd(8'h4C, 32'd0, "R9");
        pin(1, 1'b0, "R9 irq");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule